// File: doc/BRIEF.md
# Interleaved Coarse Delay Channel

This block is one channel of a digital edge placer. Two event inputs, A and B, fire on low-to-high transitions. They are sampled on a half-rate retiming strobe, which is every second cycle of the high-speed clock `clk`. When a rising edge is seen at a retiming sample, the 10-bit delay code is captured on that same sample, so the strobe comes from the detected edge and no free-running capture is involved.

The upper three code bits choose how many high-speed cycles the event spends in a shift-register chain. The lower seven bits travel with the event and are presented on `fine_o` for an external fine vernier. When the event leaves the chain, the block emits a fixed-width pulse. That width is a 2 ns target rounded to whole high-speed cycles, which is 2 cycles at the default 1.25 ns period.

The fine stage accepts events only when they are at least four high-speed cycles apart. An event that arrives sooner is dropped and raises `refire_viol_o`. A half-span mode restricts codes to the lower half of the range, and any code with its top bit set in that mode raises `range_err_o`.

Top module: `edge_delay_channel`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `pulse_o`, `refire_viol_o` and `range_err_o` are low. An event captured before a reset never produces a pulse after it.
- R2: Retiming samples occur on the 2nd, 4th, 6th, … rising edge of `clk` after reset is released. A rising edge of `in_a` seen at a sample starts an event with coarse delay k = `code_i[9:7]`. `pulse_o` is first high right after the (k+2)-th clock edge following that sample.
- R3: Every output pulse lasts exactly 2 high-speed cycles (PULSE_PS rounded to clock periods).
- R4: `fine_o` equals `code_i[6:0]` as captured at the sampling edge. It is stable for the whole pulse, and changes to `code_i` after that edge do not affect it.
- R5: An input counts as an event only if it is high at a sample and was low at the previous sample. A high level lasting only between two samples produces no pulse. A level held high produces exactly one pulse.
- R6: `in_b` used alone behaves exactly like `in_a`, with the same latency, width and fine code.
- R7: If A and B both rise at the same sample, A is launched first and B one cycle later with the same code. B then reaches the fine stage one cycle after A, so it is dropped and `refire_viol_o` pulses right after edge k+3.
- R8: An event that reaches the fine stage fewer than 4 cycles after the previous emitted pulse began is dropped, and `refire_viol_o` pulses for one cycle. A spacing of exactly 4 cycles is accepted.
- R9: With `half_span` = 1, a launched code with bit 9 set raises `range_err_o` for one cycle right after its launch edge, and the event is still emitted. With `half_span` = 0 the flag never rises.
- R10: If a new event would enter the chain at the stage an older event is moving into, both would reach the fine stage together. The older event is kept, the newer one is dropped, and `refire_viol_o` pulses right after the edge following the newer event's sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock; the retiming strobe runs at half its rate |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Event input A, rising-edge sensitive |
| in_b | input | 1 | Event input B, rising-edge sensitive |
| code_i | input | 10 | Delay code: [9:7] coarse cycles, [6:0] fine code |
| half_span | input | 1 | Half-span mode, in which bit 9 of the code is out of range |
| pulse_o | output | 1 | Delayed fixed-width output pulse |
| fine_o | output | 7 | Fine code of the pulse currently emitted |
| refire_viol_o | output | 1 | One-cycle flag: an event was dropped for spacing or collision |
| range_err_o | output | 1 | One-cycle flag: out-of-range code in half-span mode |

## Verification
Simultaneous A and B edges are driven at every coarse delay of interest. A design that deferred B to the next retiming sample, or that did not drop it, would show a second pulse or would move the violation by one cycle.

Spacing is tested on both sides of the limit: exactly four cycles must pass and two cycles must be dropped. An off-by-one in the gap counter shows up as a lost pulse or an extra one. A short event overtakes a long one in the chain, and the check confirms that the older fine code survives. A block that let the newer event overwrite the stage would emit the wrong `fine_o` and lose the flag.

Sub-sample glitches, held levels and a reset taken while an event is in flight catch edge detectors that are level-sensitive or that forget their state.

// File: rtl/edc_pkg.sv
package edc_pkg;

  // Rounds a pulse width in picoseconds to the nearest whole clock count (min 1).
  function automatic int ps_to_cycles(input int width_ps, input int period_ps);
    int n;
    n = (width_ps + period_ps / 2) / period_ps;
    return (n < 1) ? 1 : n;
  endfunction

  // Out-of-range test for the half-span mode.
  function automatic logic span_bad(input logic half, input logic code_msb);
    return half & code_msb;
  endfunction

endpackage

// File: rtl/edc_front.sv
module edc_front #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              half_span,
  input  logic [CODE_W-1:0] code_i,
  output logic              launch_v,
  output logic [CODE_W-1:0] launch_code,
  output logic              range_err
);

  logic              ph;        // high on the edge that acts as a retiming sample
  logic              a_q, b_q;  // input levels at the previous sample
  logic              held_v;    // deferred B launch
  logic [CODE_W-1:0] held_code;
  logic              rise_a, rise_b;

  assign rise_a = ph & in_a & ~a_q;
  assign rise_b = ph & in_b & ~b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= 1'b0;
      a_q         <= 1'b0;
      b_q         <= 1'b0;
      held_v      <= 1'b0;
      held_code   <= '0;
      launch_v    <= 1'b0;
      launch_code <= '0;
      range_err   <= 1'b0;
    end else begin
      ph        <= ~ph;
      launch_v  <= 1'b0;
      range_err <= 1'b0;
      if (ph) begin
        a_q <= in_a;
        b_q <= in_b;
        if (rise_a | rise_b) begin
          launch_v    <= 1'b1;
          launch_code <= code_i;
          range_err   <= edc_pkg::span_bad(half_span, code_i[CODE_W-1]);
        end
        held_v    <= rise_a & rise_b;
        held_code <= code_i;
      end else if (held_v) begin
        launch_v    <= 1'b1;
        launch_code <= held_code;
        range_err   <= edc_pkg::span_bad(half_span, held_code[CODE_W-1]);
        held_v      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/edc_coarse_line.sv
module edc_coarse_line #(
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_v,
  input  logic [COARSE_W-1:0] ins_sel,
  input  logic [FINE_W-1:0]   ins_fine,
  output logic                out_v,
  output logic [FINE_W-1:0]   out_fine,
  output logic                coll_o
);

  localparam int NSTAGE = 1 << COARSE_W;

  logic [NSTAGE-1:0] st_v;
  logic [FINE_W-1:0] st_f  [NSTAGE];
  logic [NSTAGE-1:0] nxt_v;
  logic [FINE_W-1:0] nxt_f [NSTAGE];
  logic [NSTAGE-1:0] hit;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    assign hit[i] = ins_v && (ins_sel == COARSE_W'(i));
    if (i == NSTAGE - 1) begin : g_last
      assign nxt_v[i] = 1'b0;
      assign nxt_f[i] = '0;
    end else begin : g_mid
      assign nxt_v[i] = st_v[i+1];
      assign nxt_f[i] = st_f[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v   <= '0;
      coll_o <= 1'b0;
      for (int i = 0; i < NSTAGE; i++) st_f[i] <= '0;
    end else begin
      coll_o <= |(hit & nxt_v);
      for (int i = 0; i < NSTAGE; i++) begin
        if (hit[i] && !nxt_v[i]) begin
          st_v[i] <= 1'b1;
          st_f[i] <= ins_fine;
        end else begin
          st_v[i] <= nxt_v[i];
          st_f[i] <= nxt_f[i];
        end
      end
    end
  end

  assign out_v    = st_v[0];
  assign out_fine = st_f[0];

endmodule

// File: rtl/edc_emit.sv
module edc_emit #(
  parameter int FINE_W    = 7,
  parameter int PULSE_CYC = 2,
  parameter int MIN_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_v,
  input  logic [FINE_W-1:0] ev_fine,
  output logic              pulse_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              viol_o
);

  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;   // cycles since the last accepted emission, saturating

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      gap    <= GW'(MIN_GAP);
      fine_o <= '0;
      viol_o <= 1'b0;
    end else begin
      viol_o <= 1'b0;
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (gap < GW'(MIN_GAP)) gap <= gap + GW'(1);
      if (ev_v) begin
        if (gap >= GW'(MIN_GAP)) begin
          cnt    <= CW'(PULSE_CYC);
          gap    <= GW'(1);
          fine_o <= ev_fine;
        end else begin
          viol_o <= 1'b1;
        end
      end
    end
  end

  assign pulse_o = (cnt != '0);

endmodule

// File: rtl/edge_delay_channel.sv
module edge_delay_channel #(
  parameter int CODE_W       = 10,
  parameter int COARSE_W     = 3,
  parameter int PULSE_PS     = 2000,
  parameter int HS_PERIOD_PS = 1250,
  parameter int MIN_GAP      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_a,
  input  logic                         in_b,
  input  logic [CODE_W-1:0]            code_i,
  input  logic                         half_span,
  output logic                         pulse_o,
  output logic [CODE_W-COARSE_W-1:0]   fine_o,
  output logic                         refire_viol_o,
  output logic                         range_err_o
);

  localparam int FINE_W    = CODE_W - COARSE_W;
  localparam int PULSE_CYC = edc_pkg::ps_to_cycles(PULSE_PS, HS_PERIOD_PS);

  logic              launch_v;
  logic [CODE_W-1:0] launch_code;
  logic              line_v;
  logic [FINE_W-1:0] line_fine;
  logic              coll;
  logic              emit_viol;

  edc_front #(.CODE_W(CODE_W)) u_front (
    .clk         (clk),
    .rst         (rst),
    .in_a        (in_a),
    .in_b        (in_b),
    .half_span   (half_span),
    .code_i      (code_i),
    .launch_v    (launch_v),
    .launch_code (launch_code),
    .range_err   (range_err_o)
  );

  edc_coarse_line #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .ins_v    (launch_v),
    .ins_sel  (launch_code[CODE_W-1 -: COARSE_W]),
    .ins_fine (launch_code[FINE_W-1:0]),
    .out_v    (line_v),
    .out_fine (line_fine),
    .coll_o   (coll)
  );

  edc_emit #(.FINE_W(FINE_W), .PULSE_CYC(PULSE_CYC), .MIN_GAP(MIN_GAP)) u_emit (
    .clk     (clk),
    .rst     (rst),
    .ev_v    (line_v),
    .ev_fine (line_fine),
    .pulse_o (pulse_o),
    .fine_o  (fine_o),
    .viol_o  (emit_viol)
  );

  assign refire_viol_o = emit_viol | coll;

endmodule

// File: rtl/edc_chk.sv
module edc_chk #(
  parameter int FINE_W    = 7,
  parameter int PULSE_CYC = 2,
  parameter int MIN_GAP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              half_span,
  input logic              pulse_o,
  input logic [FINE_W-1:0] fine_o,
  input logic              refire_viol_o,
  input logic              range_err_o
);

  localparam int LW = $clog2(PULSE_CYC + 2);
  localparam int SW = $clog2(MIN_GAP + 1);

  logic          prev_p;
  logic [LW-1:0] hi_len;
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_p <= 1'b0;
      hi_len <= '0;
      since  <= SW'(MIN_GAP);
    end else begin
      prev_p <= pulse_o;
      if (pulse_o) begin
        if (hi_len < LW'(PULSE_CYC + 1)) hi_len <= hi_len + LW'(1);
      end else begin
        hi_len <= '0;
      end
      if (pulse_o && !prev_p) since <= SW'(1);
      else if (since < SW'(MIN_GAP)) since <= since + SW'(1);
    end
  end

  // R1: outputs quiet on the cycle after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pulse_o && !refire_viol_o && !range_err_o));

  // R3: each pulse lasts exactly PULSE_CYC cycles
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && prev_p) |-> (hi_len == LW'(PULSE_CYC)));

  // R4: fine code holds while the pulse is high
  p_fine_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && prev_p) |-> $stable(fine_o));

  // R8: pulse starts are never closer than MIN_GAP
  p_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && !prev_p) |-> (since >= SW'(MIN_GAP)));

  // R9: range flag only follows a launch taken in half-span mode
  p_range_cause_r9: assert property (@(posedge clk) disable iff (rst)
    range_err_o |-> $past(half_span));

endmodule

bind edge_delay_channel edc_chk #(
  .FINE_W(FINE_W), .PULSE_CYC(PULSE_CYC), .MIN_GAP(MIN_GAP)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .half_span     (half_span),
  .pulse_o       (pulse_o),
  .fine_o        (fine_o),
  .refire_viol_o (refire_viol_o),
  .range_err_o   (range_err_o)
);

// File: tb/tb_edge_delay_channel.sv
module tb_edge_delay_channel;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_a = 1'b0, in_b = 1'b0, half_span = 1'b0;
  logic [9:0] code = '0;
  logic       pulse_o, refire_viol_o, range_err_o;
  logic [6:0] fine_o;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int w_first_rise, w_rises, w_high, w_fine, w_viols, w_first_viol, w_ranges;

  // fields: [12]=A, [11]=B, [10]=half_span, [9:0]=code
  localparam logic [12:0] VEC [8] = '{
    {3'b100, 10'h000}, {3'b100, 10'h3FF}, {3'b010, 10'h1A5}, {3'b101, 10'h2C3},
    {3'b011, 10'h0FF}, {3'b110, 10'h155}, {3'b111, 10'h380}, {3'b011, 10'h27F}
  };

  edge_delay_channel dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .code_i(code),
    .half_span(half_span), .pulse_o(pulse_o), .fine_o(fine_o),
    .refire_viol_o(refire_viol_o), .range_err_o(range_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Observe n cycles from the negedge after the current edge; optional actions.
  task automatic watch(input int n, input int low_t, input int r2, input logic [9:0] c2);
    logic prev;
    prev = pulse_o;
    w_first_rise = -1; w_rises = 0; w_high = 0; w_fine = -1;
    w_viols = 0; w_first_viol = -1; w_ranges = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (pulse_o && !prev) begin
        if (w_rises == 0) begin w_first_rise = t; w_fine = int'(fine_o); end
        w_rises++;
      end
      if (pulse_o) w_high++;
      if (refire_viol_o) begin
        if (w_viols == 0) w_first_viol = t;
        w_viols++;
      end
      if (range_err_o) w_ranges++;
      prev = pulse_o;
      if (t == low_t) begin in_a = 1'b0; in_b = 1'b0; code = ~code; end
      if (r2 >= 0 && t == r2 - 1) begin in_a = 1'b1; code = c2; end
      if (r2 >= 0 && t == r2 + 1) in_a = 1'b0;
    end
  endtask

  task automatic run_event(input logic ua, input logic ub, input logic hs,
                           input logic [9:0] c, input int r2, input logic [9:0] c2);
    do @(negedge clk); while (cyc[0] == 1'b0);
    in_a = ua; in_b = ub; half_span = hs; code = c;
    @(posedge clk);
    watch(16, 1, r2, c2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 pulse in reset", int'(pulse_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pulse after reset", int'(pulse_o), 0);
    chk("R1 viol after reset", int'(refire_viol_o), 0);
    chk("R1 range after reset", int'(range_err_o), 0);

    // vector table: R2 R3 R4 R6 R7 R9
    for (int v = 0; v < 8; v++) begin
      logic ua, ub, hs;
      logic [9:0] c;
      int k;
      {ua, ub, hs, c} = VEC[v];
      k = int'(c[9:7]);
      run_event(ua, ub, hs, c, -1, 10'h000);
      chk(ub && !ua ? "R6 latency via B" : "R2 latency", w_first_rise, k + 2);
      chk("R3 pulse width", w_high, 2);
      chk("R4 fine code", w_fine, int'(c[6:0]));
      chk("R7 B drop count", w_viols, (ua && ub) ? 1 : 0);
      if (ua && ub) chk("R7 B drop cycle", w_first_viol, k + 3);
      chk("R9 range flags", w_ranges, (hs && c[9]) ? ((ua && ub) ? 2 : 1) : 0);
      repeat (4) @(negedge clk);
    end

    // R8: spacing of exactly 4 accepted
    run_event(1'b1, 1'b0, 1'b0, 10'h000, 4, 10'h005);
    chk("R8 gap4 pulses", w_rises, 2);
    chk("R8 gap4 no flag", w_viols, 0);
    repeat (4) @(negedge clk);

    // R8: spacing of 2 dropped
    run_event(1'b1, 1'b0, 1'b0, 10'h100, 4, 10'h000);
    chk("R8 gap2 pulses", w_rises, 1);
    chk("R8 gap2 flag count", w_viols, 1);
    chk("R8 gap2 flag cycle", w_first_viol, 6);
    repeat (4) @(negedge clk);

    // R10: newer short event collides with older long one
    run_event(1'b1, 1'b0, 1'b0, 10'h291, 4, 10'h0AA);
    chk("R10 collision flag cycle", w_first_viol, 5);
    chk("R10 collision flag count", w_viols, 1);
    chk("R10 pulses", w_rises, 1);
    chk("R10 older kept (cycle)", w_first_rise, 7);
    chk("R10 older kept (fine)", w_fine, 'h11);
    repeat (4) @(negedge clk);

    // R5: level high only between samples is ignored
    do @(negedge clk); while (cyc[0] == 1'b1);
    in_a = 1'b1; code = 10'h000;
    @(negedge clk);
    in_a = 1'b0;
    watch(14, -1, -1, 10'h000);
    chk("R5 glitch ignored", w_rises, 0);

    // R5: held level gives one event
    do @(negedge clk); while (cyc[0] == 1'b0);
    in_b = 1'b1; code = 10'h080;
    watch(20, -1, -1, 10'h000);
    chk("R5 held level one pulse", w_rises, 1);
    in_b = 1'b0;
    repeat (6) @(negedge clk);

    // R1: reset with an event in flight
    do @(negedge clk); while (cyc[0] == 1'b0);
    in_a = 1'b1; code = 10'h380;
    @(negedge clk);
    in_a = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    watch(14, -1, -1, 10'h000);
    chk("R1 in-flight event cleared", w_rises, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule